// File: doc/BRIEF.md
# Three-Pair Motor-Control PWM Generator

This block drives three complementary PWM output pairs, a high side and a low side per pair, from one shared period counter. The counter runs in either an edge-aligned sawtooth or a center-aligned triangle. It advances once per prescaled tick, where the tick rate is the system clock divided by 1, 2, 4 or 8. Each pair compares the counter with its own duty value. The high side is active while the counter is below that value, and the low side is active otherwise.

The period, the three duty values and the prescale code arrive on plain input ports that act as shadow registers. Software sets a ready flag once all of them are written. At the next reload event the block copies them into its active registers and clears the flag. A reload event falls at the end of every 1st, 2nd, 4th or 8th period. A rising run enable starts the counter and loads the active registers at once, so the first period already uses the new settings. Two option inputs choose the idle level of the high-side group and of the low-side group, and the active level is the opposite one. A global enable drives the pad output enable. When the enable is low, or while reset is asserted, the pins are high-impedance.

Top module: `mcpwm`

## Requirements
- R1: While `rst_ni` is low, `pwm_oe_o` is 0. On the first clock edge after reset is released, `pwm_oe_o` takes the value of `mc_en_i`.
- R2: `mc_en_i` low at a clock edge makes `pwm_oe_o` 0 after that edge, which tri-states all six pins.
- R3: While the counter is not running, every bit of `pwm_h_o` equals `hi_off_i` and every bit of `pwm_l_o` equals `lo_off_i`. The active level of each group is the inverse of its idle level.
- R4: In edge-aligned mode (`center_i`=0) the counter steps 0,1,…,P and then returns to 0, which gives a period of (P+1) ticks. High side i is active while counter < duty[i], and low side i is active whenever high side i is not.
- R5: In center-aligned mode (`center_i`=1) the counter steps 0,1,…,P,P-1,…,1 and then returns to 0, which gives a period of 2·P ticks (1 tick when P=0).
- R6: A tick lasts 2^code system clocks, where code is the active prescale value. A new `psc_i` has no effect until it is transferred.
- R7: A duty value of 0 keeps the high side idle for the whole period. A duty value above P keeps it active for the whole period.
- R8: A reload event occurs on every 2^`relfreq_i`-th period end, counted from the start of the run.
- R9: `ready_o` is set by a pulse on `ready_set_i` and clears in the cycle the shadow transfer happens (a set in that same cycle wins). The transfer happens only at a reload event while `ready_o` is 1. Later reload events keep the active values.
- R10: A rising edge of `run_i` restarts the counter at 0 and loads all active registers immediately, whether or not `ready_o` is set, and clears `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mc_en_i | input | 1 | Global output enable for the six pins |
| run_i | input | 1 | Counter run enable; its rising edge restarts and loads |
| center_i | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| hi_off_i | input | 1 | Idle level of the high-side group |
| lo_off_i | input | 1 | Idle level of the low-side group |
| relfreq_i | input | 2 | Reload every 2^code periods |
| ready_set_i | input | 1 | Pulse that marks the shadow values complete |
| period_i | input | CNT_W | Shadow period value P |
| cmp_i | input | N_CH×CNT_W | Shadow duty values, pair i in slice i |
| psc_i | input | 2 | Shadow prescale code (divide by 2^code) |
| ready_o | output | 1 | Transfer pending flag |
| pwm_oe_o | output | 1 | Pad output enable; 0 = all pins high-impedance |
| pwm_h_o | output | N_CH | High-side outputs |
| pwm_l_o | output | N_CH | Low-side outputs |

## Verification
Directed cases measure the whole period and the active time in both counter modes, first with divide-by-1 and then with divide-by-4. These measurements tell the sawtooth, triangle and prescale lengths apart. The duty values 0 and above-period separate the two saturated extremes from an ordinary compare. A shadow write made without the ready flag is shown to be held back over several reload events. The ready-to-transfer delay is measured with an eighth-period reload rate. A run restart is shown to load without the ready flag. Random stretches change the period, duties, prescale code, reload rate, mode, idle levels and enables at random. They are checked every cycle against a bench model of the counting sequence, which exposes faults in mode switching and in reload timing while both are in motion.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  typedef logic [1:0] psc_t;
  typedef logic [1:0] relf_t;
  typedef enum logic {ALIGN_EDGE = 1'b0, ALIGN_CENTER = 1'b1} align_e;
endpackage

// File: rtl/mcpwm_shadow.sv
module mcpwm_shadow
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        reload_i,
  input  logic                        ready_set_i,
  input  logic [CNT_W-1:0]            sh_period_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  sh_cmp_i,
  input  psc_t                        sh_psc_i,
  output logic                        ready_o,
  output logic                        load_o,
  output logic [CNT_W-1:0]            period_o,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_o,
  output psc_t                        psc_o
);
  logic ready_q;

  assign load_o  = start_i | (reload_i & ready_q);
  assign ready_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      period_o <= '0;
      cmp_o    <= '0;
      psc_o    <= '0;
    end else begin
      if (ready_set_i)  ready_q <= 1'b1;
      else if (load_o)  ready_q <= 1'b0;
      if (load_o) begin
        period_o <= sh_period_i;
        cmp_o    <= sh_cmp_i;
        psc_o    <= sh_psc_i;
      end
    end
  end

  assert_ready_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !ready_set_i) |=> !ready_o);
  assert_active_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> ($stable(psc_o) && $stable(period_o) && $stable(cmp_o)));
endmodule

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  align_e           align_i,
  input  logic [CNT_W-1:0] period_i,
  input  psc_t             psc_i,
  input  relf_t            relfreq_i,
  output logic             start_o,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o
);
  localparam int PRE_W = 3;

  logic             run_q, up_q, up_n, tick, wrap;
  logic [PRE_W-1:0] pre_q, pre_lim, rl_q, rl_lim;
  logic [CNT_W-1:0] cnt_q, nxt;

  assign start_o   = run_i & ~run_q;
  assign running_o = run_q;
  assign cnt_o     = cnt_q;
  assign pre_lim   = PRE_W'((4'd1 << psc_i) - 4'd1);
  assign rl_lim    = PRE_W'((4'd1 << relfreq_i) - 4'd1);
  assign tick      = run_q && (pre_q == pre_lim);
  assign reload_o  = tick && wrap && (rl_q >= rl_lim);

  always_comb begin
    nxt  = cnt_q;
    up_n = up_q;
    if (align_i == ALIGN_CENTER) begin
      if (up_q) begin
        if (cnt_q >= period_i) begin
          nxt  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          up_n = (nxt == '0);
        end else begin
          nxt = cnt_q + 1'b1;
        end
      end else begin
        nxt  = cnt_q - 1'b1;
        up_n = (nxt == '0);
      end
      wrap = (nxt == '0) && ((cnt_q != '0) || (period_i == '0));
    end else begin
      wrap = (cnt_q >= period_i);
      nxt  = wrap ? '0 : cnt_q + 1'b1;
      up_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      up_q  <= 1'b1;
      cnt_q <= '0;
      pre_q <= '0;
      rl_q  <= '0;
    end else begin
      run_q <= run_i;
      if (start_o) begin
        up_q  <= 1'b1;
        cnt_q <= '0;
        pre_q <= '0;
        rl_q  <= '0;
      end else if (run_q) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) begin
          cnt_q <= nxt;
          up_q  <= up_n;
          if (wrap) rl_q <= (rl_q >= rl_lim) ? '0 : rl_q + 1'b1;
        end
      end
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |-> (cnt_o <= period_i));
  assert_restart_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (cnt_o == '0));
  assert_hold_between_ticks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !tick && !start_o) |=> $stable(cnt_o));
endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair #(
  parameter int CNT_W = 8
) (
  input  logic             running_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             hi_off_i,
  input  logic             lo_off_i,
  output logic             h_o,
  output logic             l_o
);
  logic below;
  assign below = cnt_i < cmp_i;
  assign h_o   = (running_i &&  below) ? ~hi_off_i : hi_off_i;
  assign l_o   = (running_i && !below) ? ~lo_off_i : lo_off_i;
endmodule

// File: rtl/mcpwm.sv
module mcpwm
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mc_en_i,
  input  logic                        run_i,
  input  logic                        center_i,
  input  logic                        hi_off_i,
  input  logic                        lo_off_i,
  input  logic [1:0]                  relfreq_i,
  input  logic                        ready_set_i,
  input  logic [CNT_W-1:0]            period_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  cmp_i,
  input  logic [1:0]                  psc_i,
  output logic                        ready_o,
  output logic                        pwm_oe_o,
  output logic [N_CH-1:0]             pwm_h_o,
  output logic [N_CH-1:0]             pwm_l_o
);
  logic                       start, reload, load, running;
  logic [CNT_W-1:0]           cnt, period_act;
  logic [N_CH-1:0][CNT_W-1:0] cmp_act;
  psc_t                       psc_act;
  logic                       oe_q;

  // pads stay high-impedance through reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= mc_en_i;
  end
  assign pwm_oe_o = oe_q;

  mcpwm_shadow #(.CNT_W(CNT_W), .N_CH(N_CH)) u_shadow (
    .clk_i, .rst_ni,
    .start_i(start), .reload_i(reload), .ready_set_i,
    .sh_period_i(period_i), .sh_cmp_i(cmp_i), .sh_psc_i(psc_t'(psc_i)),
    .ready_o, .load_o(load),
    .period_o(period_act), .cmp_o(cmp_act), .psc_o(psc_act)
  );

  mcpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i, .rst_ni, .run_i,
    .align_i(align_e'(center_i)), .period_i(period_act),
    .psc_i(psc_act), .relfreq_i(relf_t'(relfreq_i)),
    .start_o(start), .running_o(running), .cnt_o(cnt), .reload_o(reload)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_pair
    mcpwm_pair #(.CNT_W(CNT_W)) u_pair (
      .running_i(running), .cnt_i(cnt), .cmp_i(cmp_act[i]),
      .hi_off_i, .lo_off_i, .h_o(pwm_h_o[i]), .l_o(pwm_l_o[i])
    );
    assert_zero_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_act[i] == '0) |-> (pwm_h_o[i] == hi_off_i));
    assert_full_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && cmp_act[i] > period_act) |-> (pwm_h_o[i] != hi_off_i));
  end

  assert_idle_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> (pwm_h_o == {N_CH{hi_off_i}} && pwm_l_o == {N_CH{lo_off_i}}));
  assert_complement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> ((pwm_h_o ^ {N_CH{hi_off_i}}) == ~(pwm_l_o ^ {N_CH{lo_off_i}})));
  assert_disable_tristate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_en_i |=> !pwm_oe_o);
endmodule

// File: tb/tb_mcpwm.sv
module tb_mcpwm;
  localparam int W = 8;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #10 clk = ~clk;

  logic mc_en, run, center, hi_off, lo_off, rdy_set;
  logic [1:0] relf, psc;
  logic [W-1:0] per;
  logic [N-1:0][W-1:0] cmp;
  logic rdy, oe;
  logic [N-1:0] h, l;

  mcpwm #(.CNT_W(W), .N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mc_en_i(mc_en), .run_i(run),
    .center_i(center), .hi_off_i(hi_off), .lo_off_i(lo_off),
    .relfreq_i(relf), .ready_set_i(rdy_set), .period_i(per), .cmp_i(cmp),
    .psc_i(psc), .ready_o(rdy), .pwm_oe_o(oe), .pwm_h_o(h), .pwm_l_o(l)
  );

  int n_vec = 0;
  int n_err = 0;
  bit chk_en = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  // reference model of the counting sequence and shadow transfer
  logic m_oe, m_run, m_up, m_rdy;
  logic [W-1:0] m_cnt, m_per;
  logic [N-1:0][W-1:0] m_cmp;
  logic [1:0] m_psc;
  logic [2:0] m_pre, m_rl;
  logic t_start, t_tick, t_wrap, t_rel, t_ld, t_up;
  logic [W-1:0] t_nxt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe <= 0; m_run <= 0; m_up <= 1; m_rdy <= 0; m_cnt <= 0;
      m_per <= 0; m_cmp <= '0; m_psc <= 0; m_pre <= 0; m_rl <= 0;
    end else begin
      t_start = run && !m_run;
      t_tick  = m_run && (m_pre == 3'((4'd1 << m_psc) - 4'd1));
      t_up = m_up; t_nxt = m_cnt;
      if (center) begin
        if (m_up && m_cnt >= m_per) begin
          t_nxt = (m_cnt == 0) ? '0 : m_cnt - 1; t_up = (t_nxt == 0);
        end else if (m_up) t_nxt = m_cnt + 1;
        else begin t_nxt = m_cnt - 1; t_up = (t_nxt == 0); end
        t_wrap = (t_nxt == 0) && (m_cnt != 0 || m_per == 0);
      end else begin
        t_wrap = m_cnt >= m_per; t_nxt = t_wrap ? '0 : m_cnt + 1; t_up = 1;
      end
      t_rel = t_tick && t_wrap && (m_rl >= 3'((4'd1 << relf) - 4'd1));
      t_ld  = t_start || (t_rel && m_rdy);
      m_oe  <= mc_en;
      m_run <= run;
      if (t_start) begin
        m_cnt <= 0; m_up <= 1; m_pre <= 0; m_rl <= 0;
      end else if (m_run) begin
        m_pre <= t_tick ? 3'd0 : m_pre + 3'd1;
        if (t_tick) begin
          m_cnt <= t_nxt; m_up <= t_up;
          if (t_wrap) m_rl <= t_rel ? 3'd0 : m_rl + 3'd1;
        end
      end
      if (t_ld) begin m_per <= per; m_cmp <= cmp; m_psc <= psc; end
      m_rdy <= rdy_set ? 1'b1 : (t_ld ? 1'b0 : m_rdy);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      string tag;
      logic [N-1:0] eh, el;
      tag = !m_run ? "R3" : (center ? "R5" : "R4");
      for (int i = 0; i < N; i++) begin
        eh[i] = (m_run && m_cnt < m_cmp[i]) ? ~hi_off : hi_off;
        el[i] = (m_run && !(m_cnt < m_cmp[i])) ? ~lo_off : lo_off;
      end
      chk({tag, " high side"}, int'(h), int'(eh));
      chk({tag, " low side"}, int'(l), int'(el));
      chk("R2 output enable", int'(oe), int'(m_oe));
      chk("R9 ready flag", int'(rdy), int'(m_rdy));
    end
  end

  // period and active time of pair 0 between two rising edges (active level 1)
  task automatic measure(output int p, output int a);
    logic prev;
    int guard;
    p = 0; a = 0; guard = 0;
    prev = h[0];
    @(negedge clk);
    while (!(h[0] && !prev) && guard < 1000) begin
      prev = h[0]; @(negedge clk); guard++;
    end
    do begin
      p++; if (h[0]) a++;
      prev = h[0]; @(negedge clk); guard++;
    end while (!(h[0] && !prev) && guard < 2000);
  endtask

  task automatic restart();
    run = 0; @(negedge clk);
    run = 1; @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, a, n, cnt0, cnt1;
    void'($urandom(32'd1234));
    mc_en = 1; run = 0; center = 0; hi_off = 0; lo_off = 1; rdy_set = 0;
    relf = 0; psc = 0; per = 8'd4; cmp = '0;
    #1 rst_n = 0;
    #1 chk("R1 oe in reset", int'(oe), 0);
    chk("R3 idle high in reset", int'(h), 0);
    chk("R3 idle low in reset", int'(l), 7);
    repeat (3) @(negedge clk);
    chk("R1 oe held in reset", int'(oe), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe after first edge", int'(oe), 1);
    chk_en = 1;

    mc_en = 0; @(negedge clk);
    chk("R2 disable tri-states", int'(oe), 0);
    mc_en = 1; @(negedge clk);

    hi_off = 1; lo_off = 0; #1;
    chk("R3 idle high follows option", int'(h), 7);
    chk("R3 idle low follows option", int'(l), 0);
    @(negedge clk); hi_off = 0; lo_off = 1;

    // edge-aligned, divide by 1
    per = 8'd5; cmp[0] = 8'd2; psc = 2'd0; relf = 0;
    restart();
    measure(p, a);
    chk("R4 edge period", p, 6);
    chk("R4 edge active time", a, 2);
    // prescale write without ready stays shadowed
    psc = 2'd2;
    repeat (20) @(negedge clk);
    measure(p, a);
    chk("R6 prescale held in shadow", p, 6);
    rdy_set = 1; @(negedge clk); rdy_set = 0;
    repeat (30) @(negedge clk);
    measure(p, a);
    chk("R6 divide-by-4 period", p, 24);
    chk("R6 divide-by-4 active time", a, 8);

    // center-aligned
    center = 1; psc = 0; per = 8'd5; cmp[0] = 8'd2;
    restart();
    measure(p, a);
    chk("R5 center period", p, 10);
    chk("R5 center active time", a, 3);

    // duty extremes
    center = 0; per = 8'd5; cmp[0] = 8'd0; cmp[1] = 8'd6;
    restart();
    cnt0 = 0; cnt1 = 0;
    for (int k = 0; k < 30; k++) begin
      if (h[0]) cnt0++;
      if (h[1]) cnt1++;
      @(negedge clk);
    end
    chk("R7 zero duty never active", cnt0, 0);
    chk("R7 duty above period always active", cnt1, 30);

    // reload every 8 periods, ready clears at transfer
    per = 8'd4; relf = 2'd3; cmp[0] = 8'd1;
    restart();
    cmp[0] = 8'd3;
    rdy_set = 1; @(negedge clk); rdy_set = 0;
    n = 1;
    while (rdy && n < 1000) begin @(negedge clk); n++; end
    chk("R8 ready clears at eighth period end", n, 40);
    measure(p, a);
    chk("R9 transferred duty", a, 3);
    cmp[0] = 8'd2;
    repeat (100) @(negedge clk);
    measure(p, a);
    chk("R9 duty kept without ready", a, 3);
    chk("R9 ready stays clear", int'(rdy), 0);

    // restart loads without ready
    run = 0; @(negedge clk);
    run = 1; @(negedge clk);
    cnt0 = 0;
    for (int k = 0; k < 5; k++) begin
      if (h[0]) cnt0++;
      @(negedge clk);
    end
    chk("R10 restart loads new duty", cnt0, 2);

    // constrained random stretch against the model
    for (int k = 0; k < 6000; k++) begin
      rdy_set = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) begin
        per = W'($urandom_range(0, 12));
        for (int i = 0; i < N; i++) cmp[i] = W'($urandom_range(0, 14));
        psc = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) == 0) relf = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) run = ~run;
      if ($urandom_range(0, 149) == 0) center = ~center;
      if ($urandom_range(0, 99) == 0) hi_off = ~hi_off;
      if ($urandom_range(0, 99) == 0) lo_off = ~lo_off;
      if ($urandom_range(0, 299) == 0) mc_en = ~mc_en;
      if (!run && $urandom_range(0, 9) == 0) run = 1;
      @(negedge clk);
    end
    rdy_set = 0;
    @(negedge clk);
    finish_run();
  end
endmodule